// File: doc/BRIEF.md
# SD Command Line Issue Engine

This block owns the CMD line of an SD/MMC card interface. Software loads a 32-bit argument and then writes a command word. The command word holds a 6-bit command index and control flags. When the launch flag is set, the engine sends a 48-bit command token one bit per SD bit period, most significant bit first, and computes the token checksum as the bits go out. A strobe `tick_i`, one system clock wide and raised once per SD bit period, sets the pace. The clock generator that produces this strobe is outside the block.

When the command word asks for a reply, the engine waits for a start bit from the card and captures either a 48-bit or a 136-bit frame. It checks the CRC7 of the frame and moves the payload into four 32-bit response words. It also records the index the card echoed, together with the application-command flag. Every outcome is recorded in sticky status bits: command sent, reply CRC good, reply CRC bad and reply timeout. Software clears these bits with a write-one-to-clear mask. A soft-reset flag in the command word aborts any command in progress and returns the engine to its idle state.

Top module: `sd_cmd_engine`

## Requirements
- R1: After `rst_ni` is released, `status_o`, `cmd_rdata_o`, `resp_o` and `resp_idx_o` are all zero, `sd_cmd_oe_o` is low and `sd_cmd_o` is high.
- R2: The command word has these fields: index in bits 5:0, need-reply in bit 6, long-reply in bit 7, application flag in bit 8, launch in bit 9 and soft reset in bit 10. Writing it with bit 9 set starts a command. `cmd_rdata_o[9]` reads 1 while that command runs and drops to 0 by itself when the command completes.
- R3: The token is 48 bits, sent MSB first with one bit per tick: 0, 1, index[5:0], argument[31:0], CRC7, 1. The CRC7 uses polynomial x^7+x^3+1 with a zero initial value and covers the first 40 bits. `sd_cmd_oe_o` is high for exactly the 48 bit periods of the token.
- R4: A command with need-reply clear completes after its end bit and sets only status bit 6, the command-sent bit.
- R5: A short reply is 48 bits: start 0, transmission bit, index[5:0], payload[31:0], CRC7, end bit. The engine computes CRC7 over the first 40 bits and compares it with the received CRC7. It sets status bits 6 and 4 on a match, and bits 6 and 0 on a mismatch. The payload goes to response word 0, which is `resp_o[127:96]`; words 1 to 3 are left unchanged. `resp_idx_o` reads {application flag, received index}.
- R6: A long reply is 136 bits: start 0, transmission bit, a 6-bit header, 120 content bits, CRC7, end bit. The CRC7 covers only the 120 content bits. `resp_o` receives the last 128 bits, with word 0 the most significant and word 3 the least significant. `resp_idx_o[5:0]` receives the header. Status is set as in R5.
- R7: After the end bit of the token, each tick that samples `sd_cmd_i` high counts toward a limit of 64. A start bit sampled on tick 64 is still accepted. If tick 64 also samples high, the engine sets status bits 6 and 2 and leaves the response words and `resp_idx_o` unchanged.
- R8: Status bits are sticky. They survive later commands until a clear write with a 1 in the matching bit of `clr_mask_i`. Bits whose mask bit is 0 are not affected.
- R9: While a command runs, a command-word write that does not set bit 10 is ignored. The token in flight, the stored command fields and the outcome are unchanged, and no second command starts.
- R10: Writing bit 10 aborts any command at once, releases the line and clears status, response words and `resp_idx_o`. `cmd_rdata_o[10]` then reads 1 for RST_CYCLES clocks and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One pulse per SD bit period |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 11 | Command word value |
| arg_wr_i | input | 1 | Argument write strobe |
| arg_wdata_i | input | 32 | Argument value |
| clr_wr_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 7 | Write-one-to-clear mask for status |
| cmd_rdata_o | output | 11 | Command word readback with live launch and reset bits |
| status_o | output | 7 | Sticky status: bit 6 sent, 4 CRC good, 2 timeout, 0 CRC bad |
| resp_idx_o | output | 7 | {application flag, echoed index} |
| resp_o | output | 128 | Response words 0..3, word 0 in bits 127:96 |
| sd_cmd_o | output | 1 | CMD line output value |
| sd_cmd_oe_o | output | 1 | CMD line output enable |
| sd_cmd_i | input | 1 | CMD line input value |

## Verification
The hardest situations to reach from the ports are the timeout boundary and a soft reset that lands while the engine is waiting for a reply. The bench drives every tick itself, one at a time. This lets it place the reply start bit on tick 63 or 64 after the token, or send nothing for 64 ticks, and it lets it issue the soft reset partway through the wait window. Stimulus vectors also cover short and long replies with correct and corrupted CRC, and a command write injected mid-token shows that the running command is not disturbed.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;
  localparam int unsigned TOKEN_BITS  = 48;
  localparam int unsigned CRC_SPAN    = 40;
  localparam int unsigned SHORT_BITS  = 48;
  localparam int unsigned LONG_BITS   = 136;
  localparam int unsigned LONG_CRC_LO = 8;
  localparam int unsigned LONG_CRC_HI = LONG_BITS - 9;
  localparam int unsigned SHORT_CRC_HI = SHORT_BITS - 9;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned NUM_WORDS   = 4;
  localparam int unsigned CW_W        = 11;
  localparam int unsigned ST_W        = 7;

  localparam int unsigned CW_NEED = 6;
  localparam int unsigned CW_LONG = 7;
  localparam int unsigned CW_APP  = 8;
  localparam int unsigned CW_EN   = 9;
  localparam int unsigned CW_RST  = 10;

  localparam int unsigned ST_SENT    = 6;
  localparam int unsigned ST_CRC_OK  = 4;
  localparam int unsigned ST_TMO     = 2;
  localparam int unsigned ST_CRC_BAD = 0;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT, RX_RECV} rx_state_e;

  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction
endpackage

// File: rtl/sd_cmd_crc7.sv
`timescale 1ns/1ps
module sd_cmd_crc7 import sd_cmd_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sd_cmd_tx.sv
`timescale 1ns/1ps
module sd_cmd_tx import sd_cmd_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        start_i,
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  input  logic        tick_i,
  output logic        active_o,
  output logic        done_o,
  output logic        bit_o
);
  localparam logic [5:0] LAST_BIT = 6'(TOKEN_BITS - 1);
  localparam logic [5:0] CRC_END  = 6'(TOKEN_BITS - 2);
  localparam logic [5:0] BODY_END = 6'(CRC_SPAN);

  logic [CRC_SPAN-1:0] sh_q;
  logic [5:0]          cnt_q;
  logic                act_q;
  logic [6:0]          crc;
  logic [2:0]          crc_sel;
  logic                crc_en;

  assign crc_en  = act_q && tick_i && (cnt_q < BODY_END);
  assign crc_sel = 3'(CRC_END - cnt_q);

  sd_cmd_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (crc_en),
    .bit_i  (sh_q[CRC_SPAN-1]),
    .crc_o  (crc)
  );

  always_comb begin
    if (!act_q)                 bit_o = 1'b1;
    else if (cnt_q < BODY_END)  bit_o = sh_q[CRC_SPAN-1];
    else if (cnt_q < LAST_BIT)  bit_o = crc[crc_sel];
    else                        bit_o = 1'b1;
  end

  assign done_o   = act_q && tick_i && (cnt_q == LAST_BIT);
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (srst_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      sh_q  <= {2'b01, idx_i, arg_i};
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q && tick_i) begin
      sh_q  <= {sh_q[CRC_SPAN-2:0], 1'b0};
      cnt_q <= cnt_q + 6'd1;
      if (cnt_q == LAST_BIT) act_q <= 1'b0;
    end
  end

  // R3
  tx_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q <= LAST_BIT));
endmodule

// File: rtl/sd_cmd_rx.sv
`timescale 1ns/1ps
module sd_cmd_rx import sd_cmd_pkg::*; #(
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srst_i,
  input  logic                 arm_i,
  input  logic                 long_i,
  input  logic                 tick_i,
  input  logic                 bit_i,
  output logic                 busy_o,
  output logic                 ok_o,
  output logic                 bad_o,
  output logic                 tmo_o,
  output logic [LONG_BITS-1:0] data_o
);
  localparam int unsigned WCNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(TIMEOUT_TICKS - 1);

  rx_state_e            st_q;
  logic [LONG_BITS-1:0] sh_q;
  logic [7:0]           cnt_q;
  logic [WCNT_W-1:0]    wcnt_q;
  logic                 long_q;
  logic                 ok_q, bad_q, tmo_q;
  logic [7:0]           last_idx;
  logic                 in_span;
  logic                 crc_en;
  logic [6:0]           crc;

  assign last_idx = long_q ? 8'(LONG_BITS - 1) : 8'(SHORT_BITS - 1);
  assign in_span  = long_q ? (cnt_q >= 8'(LONG_CRC_LO) && cnt_q <= 8'(LONG_CRC_HI))
                           : (cnt_q >= 8'd1 && cnt_q <= 8'(SHORT_CRC_HI));
  assign crc_en   = (st_q == RX_RECV) && tick_i && in_span;

  sd_cmd_crc7 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .en_i   (crc_en),
    .bit_i  (bit_i),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      long_q <= 1'b0;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
      tmo_q <= 1'b0;
      if (srst_i) begin
        st_q <= RX_IDLE;
      end else begin
        unique case (st_q)
          RX_IDLE: if (arm_i) begin
            st_q   <= RX_WAIT;
            wcnt_q <= '0;
            long_q <= long_i;
          end
          RX_WAIT: if (tick_i) begin
            if (!bit_i) begin
              st_q  <= RX_RECV;
              cnt_q <= 8'd1;
              sh_q  <= '0;
            end else if (wcnt_q == WAIT_LAST) begin
              st_q  <= RX_IDLE;
              tmo_q <= 1'b1;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
          RX_RECV: if (tick_i) begin
            sh_q  <= {sh_q[LONG_BITS-2:0], bit_i};
            cnt_q <= cnt_q + 8'd1;
            if (cnt_q == last_idx) begin
              st_q <= RX_IDLE;
              if (crc == sh_q[6:0]) ok_q  <= 1'b1;
              else                  bad_q <= 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != RX_IDLE);
  assign ok_o   = ok_q;
  assign bad_o  = bad_q;
  assign tmo_o  = tmo_q;
  assign data_o = sh_q;

  // R7
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_WAIT) |-> (wcnt_q <= WAIT_LAST));
  // R5
  rx_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_q, bad_q, tmo_q}));
endmodule

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/1ps
module sd_cmd_engine import sd_cmd_pkg::*; #(
  parameter int unsigned TIMEOUT_TICKS = 64,
  parameter int unsigned RST_CYCLES    = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic                        cmd_wr_i,
  input  logic [CW_W-1:0]             cmd_wdata_i,
  input  logic                        arg_wr_i,
  input  logic [31:0]                 arg_wdata_i,
  input  logic                        clr_wr_i,
  input  logic [ST_W-1:0]             clr_mask_i,
  output logic [CW_W-1:0]             cmd_rdata_o,
  output logic [ST_W-1:0]             status_o,
  output logic [6:0]                  resp_idx_o,
  output logic [NUM_WORDS*WORD_W-1:0] resp_o,
  output logic                        sd_cmd_o,
  output logic                        sd_cmd_oe_o,
  input  logic                        sd_cmd_i
);
  localparam int unsigned RST_W = $clog2(RST_CYCLES + 1);
  localparam int unsigned RESP_W = NUM_WORDS * WORD_W;

  logic [31:0]      arg_q;
  logic [8:0]       cmd_q;
  logic             busy_q;
  logic [RST_W-1:0] rst_cnt_q;
  logic [ST_W-1:0]  status_q, st_set, st_clr;
  logic [6:0]       idx_q;
  logic [WORD_W-1:0] resp_q [NUM_WORDS];

  logic srst, rst_busy, wr_ok, launch;
  logic tx_act, tx_done, tx_bit;
  logic rx_busy, rx_ok, rx_bad, rx_tmo, rx_done;
  logic [LONG_BITS-1:0] rx_data;
  logic finish;
  logic rx_unused;

  assign srst     = cmd_wr_i && cmd_wdata_i[CW_RST];
  assign rst_busy = (rst_cnt_q != '0);
  assign wr_ok    = cmd_wr_i && !cmd_wdata_i[CW_RST] && !busy_q && !rst_busy;
  assign launch   = wr_ok && cmd_wdata_i[CW_EN];
  assign rx_done  = rx_ok || rx_bad;
  assign finish   = (tx_done && !cmd_q[CW_NEED-0]) || rx_ok || rx_bad || rx_tmo;
  assign rx_unused = ^rx_data[LONG_BITS-1:LONG_BITS-2];

  sd_cmd_tx u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .start_i  (launch),
    .idx_i    (cmd_wdata_i[5:0]),
    .arg_i    (arg_q),
    .tick_i   (tick_i),
    .active_o (tx_act),
    .done_o   (tx_done),
    .bit_o    (tx_bit)
  );

  sd_cmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst),
    .arm_i  (tx_done && cmd_q[CW_NEED]),
    .long_i (cmd_q[CW_LONG]),
    .tick_i (tick_i),
    .bit_i  (sd_cmd_i),
    .busy_o (rx_busy),
    .ok_o   (rx_ok),
    .bad_o  (rx_bad),
    .tmo_o  (rx_tmo),
    .data_o (rx_data)
  );

  always_comb begin
    st_set = '0;
    st_set[ST_SENT]    = finish;
    st_set[ST_CRC_OK]  = rx_ok;
    st_set[ST_CRC_BAD] = rx_bad;
    st_set[ST_TMO]     = rx_tmo;
    st_clr = clr_wr_i ? clr_mask_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q     <= '0;
      cmd_q     <= '0;
      busy_q    <= 1'b0;
      rst_cnt_q <= '0;
      status_q  <= '0;
      idx_q     <= '0;
    end else begin
      if (arg_wr_i && !busy_q) arg_q <= arg_wdata_i;
      if (srst) begin
        cmd_q     <= '0;
        busy_q    <= 1'b0;
        rst_cnt_q <= RST_W'(RST_CYCLES);
        status_q  <= '0;
        idx_q     <= '0;
      end else begin
        if (rst_busy) rst_cnt_q <= rst_cnt_q - 1'b1;
        if (wr_ok) cmd_q <= cmd_wdata_i[8:0];
        if (launch)      busy_q <= 1'b1;
        else if (finish) busy_q <= 1'b0;
        status_q <= (status_q & ~st_clr) | st_set;
        if (rx_done)
          idx_q <= {cmd_q[CW_APP], cmd_q[CW_LONG] ? rx_data[LONG_BITS-3:LONG_BITS-8]
                                                  : rx_data[SHORT_BITS-3:SHORT_BITS-8]};
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam int unsigned HI = RESP_W - 1 - g * WORD_W;
    assign resp_o[HI -: WORD_W] = resp_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       resp_q[g] <= '0;
      else if (srst)     resp_q[g] <= '0;
      else if (rx_done) begin
        if (cmd_q[CW_LONG])  resp_q[g] <= rx_data[HI -: WORD_W];
        else if (g == 0)     resp_q[g] <= rx_data[SHORT_BITS-9 -: WORD_W];
      end
    end
  end

  assign cmd_rdata_o = {rst_busy, busy_q, cmd_q};
  assign status_o    = status_q;
  assign resp_idx_o  = idx_q;
  assign sd_cmd_o    = tx_bit;
  assign sd_cmd_oe_o = tx_act;

  // R3
  tx_start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_act) |-> (sd_cmd_oe_o && !sd_cmd_o));
  // R3
  no_drive_in_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_act && rx_busy));
  // R2
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(srst)) |-> status_q[ST_SENT]);
  // R10
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy |-> (!busy_q && !tx_act && !rx_busy));
endmodule

// File: tb/sim_sd_cmd_engine.sv
`timescale 1ns/1ps
module sim_sd_cmd_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmd_wr = 1'b0;
  logic [10:0] cmd_wdata = '0;
  logic arg_wr = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic clr_wr = 1'b0;
  logic [6:0] clr_mask = '0;
  logic sd_in = 1'b1;
  logic [10:0] cmd_rdata;
  logic [6:0] status, resp_idx;
  logic [127:0] resp;
  logic sd_out, sd_oe;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sd_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .arg_wr_i(arg_wr), .arg_wdata_i(arg_wdata),
    .clr_wr_i(clr_wr), .clr_mask_i(clr_mask),
    .cmd_rdata_o(cmd_rdata), .status_o(status), .resp_idx_o(resp_idx),
    .resp_o(resp), .sd_cmd_o(sd_out), .sd_cmd_oe_o(sd_oe), .sd_cmd_i(sd_in)
  );

  // idx, arg, need, long, app, mode(0 ok,1 bad crc,2 silent), delay ticks, expected status
  localparam int NV = 8;
  localparam logic [56:0] VEC [NV] = '{
    {6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 7'd0,  7'h40},
    {6'd8,  32'h0000_01AA, 1'b1, 1'b0, 1'b0, 2'd0, 7'd2,  7'h50},
    {6'd17, 32'h0000_1234, 1'b1, 1'b0, 1'b0, 2'd1, 7'd1,  7'h41},
    {6'd2,  32'h0000_0000, 1'b1, 1'b1, 1'b0, 2'd0, 7'd5,  7'h50},
    {6'd41, 32'h40FF_8000, 1'b1, 1'b0, 1'b1, 2'd0, 7'd0,  7'h50},
    {6'd9,  32'h5555_0000, 1'b1, 1'b1, 1'b0, 2'd1, 7'd3,  7'h41},
    {6'd13, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 2'd2, 7'd64, 7'h44},
    {6'd55, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 2'd0, 7'd63, 7'h50}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [119:0] d, input int n);
    logic [6:0] r = '0;
    logic inv;
    for (int i = n - 1; i >= 0; i--) begin
      inv = d[i] ^ r[6];
      r = r << 1;
      if (inv) r = r ^ 7'b000_1001;
    end
    return r;
  endfunction

  task automatic tick_bit(input logic b);
    @(negedge clk); sd_in = b; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic write_cmd(input logic [10:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic write_arg(input logic [31:0] a);
    @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
    @(negedge clk); arg_wr = 1'b0;
  endtask

  task automatic clear(input logic [6:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_mask = m;
    @(negedge clk); clr_wr = 1'b0;
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic need,
                         input logic lng, input logic app, input logic [1:0] mode, input int dly,
                         input logic [6:0] exp_st, input int poke, output logic [47:0] tok);
    logic [47:0] exp_tok;
    logic [127:0] prev_resp;
    logic [6:0] prev_idx, c;
    logic [135:0] frame;
    logic [119:0] body;
    logic [31:0] pay;
    int flen;
    bit oe_ok;
    prev_resp = resp;
    prev_idx  = resp_idx;
    exp_tok = {2'b01, idx, arg, ref_crc({80'd0, 2'b01, idx, arg}, 40), 1'b1};
    write_arg(arg);
    write_cmd({1'b0, 1'b1, app, lng, need, idx});
    chk(cmd_rdata[9] == 1'b1, "R2 launch bit busy", 128'(cmd_rdata), 128'(11'h200));
    oe_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      if (i == poke) begin
        write_arg(32'hFFFF_FFFF);
        write_cmd({1'b0, 1'b1, 3'b111, 6'h2A});
      end
      tok[47 - i] = sd_out;
      if (!sd_oe) oe_ok = 1'b0;
      tick_bit(1'b1);
    end
    chk(tok == exp_tok, "R3 token", 128'(tok), 128'(exp_tok));
    chk(oe_ok && !sd_oe, "R3 oe window", 128'(sd_oe), 128'(0));
    if (need) begin
      for (int d = 0; d < dly; d++) tick_bit(1'b1);
      pay = ~arg;
      body = {arg, ~arg, arg ^ 32'hA5A5_A5A5, arg[23:0]};
      if (lng) begin
        c = ref_crc(body, 120) ^ {6'd0, mode == 2'd1};
        frame = {2'b00, 6'h3F, body, c, 1'b1};
        flen = 136;
      end else begin
        c = ref_crc({80'd0, 2'b00, idx, pay}, 40) ^ {6'd0, mode == 2'd1};
        frame = {88'd0, 2'b00, idx, pay, c, 1'b1};
        flen = 48;
      end
      if (mode != 2'd2)
        for (int i = flen - 1; i >= 0; i--) tick_bit(frame[i]);
    end
    repeat (3) @(negedge clk);
    chk(status == exp_st, "R4/R5/R6/R7 status", 128'(status), 128'(exp_st));
    chk(cmd_rdata[9] == 1'b0, "R2 launch bit self-clear", 128'(cmd_rdata), 128'(0));
    if (need && mode == 2'd2) begin
      // R7 no reply: response storage untouched
      chk(resp == prev_resp && resp_idx == prev_idx, "R7 resp kept", resp, prev_resp);
    end else if (need && lng) begin
      chk(resp == {body, c, 1'b1}, "R6 long words", resp, {body, c, 1'b1});
      chk(resp_idx == {app, 6'h3F}, "R6 header echo", 128'(resp_idx), 128'({app, 6'h3F}));
    end else if (need) begin
      chk(resp == {pay, prev_resp[95:0]}, "R5 short word0", resp, {pay, prev_resp[95:0]});
      chk(resp_idx == {app, idx}, "R5 index echo", 128'(resp_idx), 128'({app, idx}));
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] tok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(status == 0 && cmd_rdata == 0, "R1 regs", 128'({cmd_rdata, status}), 128'(0));
    chk(resp == 0 && resp_idx == 0, "R1 resp", resp, 128'(0));
    chk(!sd_oe && sd_out, "R1 line", 128'({sd_oe, sd_out}), 128'(1));

    // R3 known answer: index 0, argument 0 ends in 0x95
    run_cmd(6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd0, 0, 7'h40, -1, tok);
    chk(tok[7:0] == 8'h95, "R3 crc known answer", 128'(tok[7:0]), 128'(8'h95));
    clear(7'h7F);

    for (int v = 0; v < NV; v++) begin
      run_cmd(VEC[v][56:51], VEC[v][50:19], VEC[v][18], VEC[v][17], VEC[v][16],
              VEC[v][15:14], int'(VEC[v][13:7]), VEC[v][6:0], -1, tok);
      clear(7'h7F);
      @(negedge clk);
      chk(status == 0, "R8 clear all", 128'(status), 128'(0));
    end

    // R8 sticky across commands, partial clear
    run_cmd(6'd17, 32'h0000_0200, 1'b1, 1'b0, 1'b0, 2'd1, 2, 7'h41, -1, tok);
    run_cmd(6'd7, 32'h0003_0000, 1'b0, 1'b0, 1'b0, 2'd0, 0, 7'h41, -1, tok);
    clear(7'h40);
    @(negedge clk);
    chk(status == 7'h01, "R8 partial clear", 128'(status), 128'(1));
    clear(7'h01);

    // R9 write during token ignored
    run_cmd(6'd6, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 2'd0, 0, 7'h40, 10, tok);
    chk(cmd_rdata[8:0] == 9'd6, "R9 fields kept", 128'(cmd_rdata), 128'(6));
    tick_bit(1'b1); tick_bit(1'b1);
    chk(!sd_oe && cmd_rdata[9] == 1'b0, "R9 no second command", 128'({sd_oe, cmd_rdata[9]}), 128'(0));
    clear(7'h7F);

    // R10 soft reset while waiting for a reply
    run_cmd(6'd3, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd1, 0, 7'h41, -1, tok);
    write_arg(32'h0000_0010);
    write_cmd({1'b0, 1'b1, 3'b001, 6'd16});
    for (int i = 0; i < 53; i++) tick_bit(1'b1);
    write_cmd(11'h400);
    chk(cmd_rdata[10] == 1'b1 && cmd_rdata[9] == 1'b0, "R10 reset bit set", 128'(cmd_rdata), 128'(11'h400));
    chk(status == 0 && resp == 0 && resp_idx == 0 && !sd_oe, "R10 cleared",
        128'({status, resp_idx, sd_oe}), 128'(0));
    repeat (4) @(negedge clk);
    chk(cmd_rdata[10] == 1'b0, "R10 reset bit self-clear", 128'(cmd_rdata), 128'(0));
    for (int i = 0; i < 80; i++) tick_bit(1'b1);
    chk(status == 0, "R10 aborted command silent", 128'(status), 128'(0));
    run_cmd(6'd8, 32'h0000_01AA, 1'b1, 1'b0, 1'b0, 2'd0, 1, 7'h50, -1, tok);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule